// File: doc/BRIEF.md
# Watchdog / Alarm Down-Counter

This block holds a 24-bit down-counter that runs in one of two modes, set by an 8-bit control register. In alarm mode it counts down once per second. Each time it reaches zero it reloads its programmed value and keeps going. In watchdog mode it counts down at 4096 Hz. When it reaches zero it stops, and it starts a 250 ms pulse. A control bit routes that pulse to either the reset output or the interrupt output. Both modes raise a sticky alarm flag when the count expires. The flag can drive the interrupt output when two enables allow it.

Software refreshes the watchdog by touching the counter. A read strobe on the counter, or a byte write to it, copies the reload value into the live count and restarts it. While the counter is disabled, its three bytes act as plain read/write storage. The tick inputs come from an oscillator and divider outside the block. Pin polarity is handled outside the block, and every output here is active-high.

Top module: `wdalm_timer`

## Requirements
- R1: After reset, the control register reads 8'h06 (only the two rate bits, bits 2 and 1, are set). `alarm_flag`, `irq`, `rst_out` and `cnt_rdata` are all 0.
- R2: The control byte bits are: 7 oscillator stop, 6 counter enable, 5 watchdog mode, 4 battery square-wave enable, 3 pulse steering, 2..1 rate select, 0 alarm interrupt enable. `osc_stop`, `sqw_batt_en` and `sqw_rate` follow bits 7, 4 and 2..1 of the stored byte.
- R3: With counter enable 0, a byte write (`cnt_sel` 0 = bits 7..0, 1 = bits 15..8, 2 = bits 23..16) lands in the count and reads back on `cnt_rdata`. Ticks leave the value unchanged.
- R4: In alarm mode (enable 1, watchdog mode 0), only `tick_sec` decrements the count. The tick that would bring the count to zero instead reloads the programmed value and sets the alarm flag.
- R5: In watchdog mode (enable 1, watchdog mode 1), only `tick_fast` decrements the count. At zero the count stays at 0 and the alarm flag is set.
- R6: A `cnt_rd` strobe or a byte write loads the live count from the reload register (including a byte written in the same cycle) and restarts a stopped watchdog.
- R7: The alarm flag drives `irq` only when the alarm interrupt enable (bit 0) is 1 and the `intcn` input is 1.
- R8: The alarm flag stays set until an `af_clr` strobe. If an expiry and `af_clr` happen in the same cycle, the flag is set.
- R9: Only a watchdog expiry starts the pulse. The pulse lasts 1024 `tick_fast` ticks. An alarm-mode expiry produces no pulse.
- R10: The pulse appears on `rst_out` when the steering bit (bit 3) is 0 and on `irq` when it is 1. The steering is captured when the pulse starts.
- R11: Clearing the alarm interrupt enable while the pulse is on `irq` does not shorten the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_fast | input | 1 | One-cycle strobe at 4096 Hz |
| tick_sec | input | 1 | One-cycle strobe at 1 Hz |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_q | output | 8 | Stored control byte |
| cnt_we | input | 1 | Counter byte write strobe |
| cnt_sel | input | 2 | Counter byte select |
| cnt_wdata | input | 8 | Counter byte write data |
| cnt_rd | input | 1 | Counter read strobe (access) |
| cnt_rdata | output | 24 | Live count |
| af_clr | input | 1 | Status write clearing the alarm flag |
| intcn | input | 1 | Interrupt-mode select from a neighbouring register |
| alarm_flag | output | 1 | Sticky alarm flag |
| osc_stop | output | 1 | Decoded oscillator-stop bit |
| sqw_batt_en | output | 1 | Decoded battery square-wave enable |
| sqw_rate | output | 2 | Decoded square-wave rate select |
| rst_out | output | 1 | Watchdog reset pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle:
- a disabled counter holds its value when it is not accessed;
- a watchdog count of zero stays at zero;
- an access loads the reload value;
- the alarm flag only clears on `af_clr`;
- `irq` is never raised without a gated flag or an active pulse;
- no pulse outlasts 1024 fast ticks.

Some properties need the bench's directed scenarios instead:
- the exact pulse length;
- that the steering is captured at the start of the pulse;
- that an alarm-mode expiry starts no pulse;
- that clearing the interrupt enable leaves a running interrupt pulse intact.

// File: rtl/wdalm_pkg.sv
package wdalm_pkg;

    // Control byte, bit 7 first
    typedef struct packed {
        logic       osc_stop;
        logic       cnt_en;
        logic       wd_mode;
        logic       sqw_batt;
        logic       wd_steer;
        logic [1:0] rate;
        logic       alarm_ie;
    } ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'h06;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_LOAD,
        CNT_STEP,
        CNT_EXPIRE
    } cnt_op_e;

    // Replace one byte lane of a word
    function automatic logic [31:0] put_byte(input logic [31:0] word,
                                             input int unsigned lane,
                                             input logic [7:0] val);
        logic [31:0] r;
        r = word;
        r[lane*8 +: 8] = val;
        return r;
    endfunction

endpackage

// File: rtl/wdalm_ctrl_reg.sv
module wdalm_ctrl_reg
    import wdalm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output ctrl_t      ctrl
);
    logic [7:0] q;

    always_ff @(posedge clk) begin
        if (rst)
            q <= CTRL_RESET;
        else if (we)
            q <= wdata;
    end

    assign ctrl = ctrl_t'(q);

endmodule

// File: rtl/wdalm_counter.sv
module wdalm_counter
    import wdalm_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             wd_mode,
    input  logic             tick_fast,
    input  logic             tick_sec,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             expire
);
    localparam int BYTES = CNT_W / 8;

    logic [CNT_W-1:0] reload_q, reload_nx, cnt_q;
    logic             halted_q, expire_q;
    logic             tick_sel, step, last;
    cnt_op_e          op;

    // Per-lane reload update
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign reload_nx[b*8 +: 8] =
            (wr_en && wr_sel == SEL_W'(b)) ? wr_data : reload_q[b*8 +: 8];
    end

    assign tick_sel = wd_mode ? tick_fast : tick_sec;
    assign step     = cnt_en && tick_sel && !(wd_mode && halted_q);
    assign last     = (cnt_q[CNT_W-1:1] == '0);

    always_comb begin
        if (wr_en || rd_en)
            op = CNT_LOAD;
        else if (step && last)
            op = CNT_EXPIRE;
        else if (step)
            op = CNT_STEP;
        else
            op = CNT_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            cnt_q    <= '0;
            halted_q <= 1'b0;
            expire_q <= 1'b0;
        end else begin
            reload_q <= reload_nx;
            expire_q <= 1'b0;
            unique case (op)
                CNT_LOAD: begin
                    cnt_q    <= reload_nx;
                    halted_q <= 1'b0;
                end
                CNT_EXPIRE: begin
                    expire_q <= 1'b1;
                    if (wd_mode) begin
                        cnt_q    <= '0;
                        halted_q <= 1'b1;
                    end else begin
                        cnt_q <= reload_q;
                    end
                end
                CNT_STEP: cnt_q <= cnt_q - 1'b1;
                default: begin
                    if (!cnt_en)
                        halted_q <= 1'b0;
                end
            endcase
        end
    end

    assign count  = cnt_q;
    assign reload = reload_q;
    assign expire = expire_q;

endmodule

// File: rtl/wdalm_pulse.sv
module wdalm_pulse #(
    parameter int PULSE_TICKS = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic steer_irq,
    input  logic tick,
    output logic active,
    output logic to_irq
);
    localparam int RW = $clog2(PULSE_TICKS + 1);

    logic [RW-1:0] rem_q;
    logic          to_irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q    <= '0;
            to_irq_q <= 1'b0;
        end else if (start) begin
            rem_q    <= RW'(PULSE_TICKS);
            to_irq_q <= steer_irq;
        end else if (tick && rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign active = (rem_q != '0);
    assign to_irq = to_irq_q;

endmodule

// File: rtl/wdalm_timer.sv
module wdalm_timer
    import wdalm_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int PULSE_TICKS = 1024,
    parameter int SEL_W       = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_fast,
    input  logic             tick_sec,
    input  logic             ctrl_we,
    input  logic [7:0]       ctrl_wdata,
    output logic [7:0]       ctrl_q,
    input  logic             cnt_we,
    input  logic [SEL_W-1:0] cnt_sel,
    input  logic [7:0]       cnt_wdata,
    input  logic             cnt_rd,
    output logic [CNT_W-1:0] cnt_rdata,
    input  logic             af_clr,
    input  logic             intcn,
    output logic             alarm_flag,
    output logic             osc_stop,
    output logic             sqw_batt_en,
    output logic [1:0]       sqw_rate,
    output logic             rst_out,
    output logic             irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload_val;
    logic             expire, pulse_start, pulse_active, pulse_to_irq;
    logic             af_q;

    wdalm_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl_we),
        .wdata (ctrl_wdata),
        .ctrl  (ctrl)
    );

    wdalm_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (ctrl.cnt_en),
        .wd_mode   (ctrl.wd_mode),
        .tick_fast (tick_fast),
        .tick_sec  (tick_sec),
        .wr_en     (cnt_we),
        .wr_sel    (cnt_sel),
        .wr_data   (cnt_wdata),
        .rd_en     (cnt_rd),
        .count     (cnt_rdata),
        .reload    (reload_val),
        .expire    (expire)
    );

    assign pulse_start = expire && ctrl.wd_mode;

    wdalm_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk       (clk),
        .rst       (rst),
        .start     (pulse_start),
        .steer_irq (ctrl.wd_steer),
        .tick      (tick_fast),
        .active    (pulse_active),
        .to_irq    (pulse_to_irq)
    );

    // Sticky alarm flag: set beats clear
    always_ff @(posedge clk) begin
        if (rst)
            af_q <= 1'b0;
        else if (expire)
            af_q <= 1'b1;
        else if (af_clr)
            af_q <= 1'b0;
    end

    assign ctrl_q      = ctrl;
    assign alarm_flag  = af_q;
    assign osc_stop    = ctrl.osc_stop;
    assign sqw_batt_en = ctrl.sqw_batt;
    assign sqw_rate    = ctrl.rate;
    assign rst_out     = pulse_active && !pulse_to_irq;
    assign irq         = (pulse_active && pulse_to_irq)
                       || (af_q && ctrl.alarm_ie && intcn);

endmodule

// File: rtl/wdalm_timer_chk.sv
module wdalm_timer_chk #(
    parameter int CNT_W       = 24,
    parameter int PULSE_TICKS = 1024
) (
    input logic             clk,
    input logic             rst,
    input logic [7:0]       ctrl_q,
    input logic             cnt_we,
    input logic             cnt_rd,
    input logic [CNT_W-1:0] cnt_rdata,
    input logic [CNT_W-1:0] reload_val,
    input logic             tick_fast,
    input logic             af_clr,
    input logic             intcn,
    input logic             alarm_flag,
    input logic             irq,
    input logic             pulse_active,
    input logic             pulse_start
);
    localparam int PW = $clog2(PULSE_TICKS + 2);
    logic [PW-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst || pulse_start)
            seen <= '0;
        else if (pulse_active && tick_fast)
            seen <= seen + 1'b1;
    end

    a_r3_disabled_holds: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[6] && !cnt_we && !cnt_rd) |=> $stable(cnt_rdata));

    a_r5_wd_stays_zero: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[6] && ctrl_q[5] && cnt_rdata == '0 && !cnt_we && !cnt_rd)
        |=> cnt_rdata == '0);

    a_r6_read_reloads: assert property (@(posedge clk) disable iff (rst)
        (cnt_rd && !cnt_we) |=> cnt_rdata == $past(reload_val));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !af_clr) |=> alarm_flag);

    a_r7_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> (pulse_active || (alarm_flag && ctrl_q[0] && intcn)));

    a_r9_pulse_bound: assert property (@(posedge clk) disable iff (rst)
        seen <= PW'(PULSE_TICKS));

endmodule

bind wdalm_timer wdalm_timer_chk #(.CNT_W(CNT_W), .PULSE_TICKS(PULSE_TICKS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctrl_q       (ctrl_q),
    .cnt_we       (cnt_we),
    .cnt_rd       (cnt_rd),
    .cnt_rdata    (cnt_rdata),
    .reload_val   (reload_val),
    .tick_fast    (tick_fast),
    .af_clr       (af_clr),
    .intcn        (intcn),
    .alarm_flag   (alarm_flag),
    .irq          (irq),
    .pulse_active (pulse_active),
    .pulse_start  (pulse_start)
);

// File: tb/wdalm_timer_test.sv
`timescale 1ns/1ps
module wdalm_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_fast = 0, tick_sec = 0;
    logic        ctrl_we = 0;
    logic [7:0]  ctrl_wdata = 0;
    logic [7:0]  ctrl_q;
    logic        cnt_we = 0;
    logic [1:0]  cnt_sel = 0;
    logic [7:0]  cnt_wdata = 0;
    logic        cnt_rd = 0;
    logic [23:0] cnt_rdata;
    logic        af_clr = 0, intcn = 0;
    logic        alarm_flag, osc_stop, sqw_batt_en, rst_out, irq;
    logic [1:0]  sqw_rate;

    int checks = 0, fails = 0, cycles = 0;

    always #2.5 clk = ~clk;

    wdalm_timer uut (
        .clk(clk), .rst(rst), .tick_fast(tick_fast), .tick_sec(tick_sec),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
        .cnt_we(cnt_we), .cnt_sel(cnt_sel), .cnt_wdata(cnt_wdata),
        .cnt_rd(cnt_rd), .cnt_rdata(cnt_rdata), .af_clr(af_clr),
        .intcn(intcn), .alarm_flag(alarm_flag), .osc_stop(osc_stop),
        .sqw_batt_en(sqw_batt_en), .sqw_rate(sqw_rate),
        .rst_out(rst_out), .irq(irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: timeout act=%0d exp<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_we = 1; ctrl_wdata = v; cyc(1); ctrl_we = 0;
    endtask

    task automatic wr_byte(input logic [1:0] s, input logic [7:0] v);
        cnt_we = 1; cnt_sel = s; cnt_wdata = v; cyc(1); cnt_we = 0;
    endtask

    task automatic rd_cnt();
        cnt_rd = 1; cyc(1); cnt_rd = 0;
    endtask

    task automatic pulse_fast(input int n);
        for (int i = 0; i < n; i++) begin
            tick_fast = 1; cyc(1); tick_fast = 0;
        end
        cyc(3);
    endtask

    task automatic pulse_sec(input int n);
        for (int i = 0; i < n; i++) begin
            tick_sec = 1; cyc(1); tick_sec = 0;
        end
        cyc(3);
    endtask

    // Apply fast ticks until the pulse drops, return ticks used
    task automatic measure(input bit on_irq, output int n);
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            tick_fast = 1; cyc(1); n++;
            if ((on_irq ? irq : rst_out) == 1'b0) break;
        end
        tick_fast = 0;
        cyc(2);
    endtask

    task automatic t_reset();
        chk("R1 ctrl", ctrl_q, 8'h06);
        chk("R1 flag", alarm_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rst_out", rst_out, 0);
        chk("R1 count", cnt_rdata, 0);
    endtask

    task automatic t_decode();
        wr_ctrl(8'h90);
        chk("R2 osc_stop", osc_stop, 1);
        chk("R2 sqw_batt_en", sqw_batt_en, 1);
        chk("R2 rate", sqw_rate, 2'b00);
        wr_ctrl(8'h04);
        chk("R2 rate 10", sqw_rate, 2'b10);
        chk("R2 osc_stop off", osc_stop, 0);
    endtask

    task automatic t_storage();
        wr_ctrl(8'h06);
        wr_byte(2'd0, 8'h12);
        wr_byte(2'd1, 8'h34);
        wr_byte(2'd2, 8'h56);
        chk("R3 storage", cnt_rdata, 24'h563412);
        pulse_fast(4);
        pulse_sec(4);
        chk("R3 ticks ignored", cnt_rdata, 24'h563412);
        chk("R3 no flag", alarm_flag, 0);
    endtask

    task automatic t_alarm();
        wr_byte(2'd2, 8'h00);
        wr_byte(2'd1, 8'h00);
        wr_byte(2'd0, 8'h03);
        wr_ctrl(8'h46);
        chk("R4 loaded", cnt_rdata, 3);
        pulse_fast(5);
        chk("R4 fast ignored", cnt_rdata, 3);
        pulse_sec(2);
        chk("R4 count down", cnt_rdata, 1);
        chk("R4 no flag yet", alarm_flag, 0);
        pulse_sec(1);
        chk("R4 reloaded", cnt_rdata, 3);
        chk("R4 flag set", alarm_flag, 1);
        chk("R9 no pulse in alarm", rst_out, 0);
        pulse_sec(1);
        chk("R4 keeps running", cnt_rdata, 2);
    endtask

    task automatic t_irq_gate();
        chk("R7 aie off", irq, 0);
        wr_ctrl(8'h47);
        intcn = 0; cyc(1);
        chk("R7 intcn off", irq, 0);
        intcn = 1; cyc(1);
        chk("R7 both on", irq, 1);
        cyc(5);
        chk("R8 sticky", alarm_flag, 1);
        af_clr = 1; cyc(1); af_clr = 0;
        chk("R8 cleared", alarm_flag, 0);
        chk("R7 irq drops", irq, 0);
        intcn = 0;
    endtask

    task automatic t_watchdog_rst();
        int n;
        wr_ctrl(8'h66);
        wr_byte(2'd0, 8'h05);
        chk("R6 write loads", cnt_rdata, 5);
        pulse_fast(3);
        chk("R5 fast counts", cnt_rdata, 2);
        pulse_sec(2);
        chk("R5 sec ignored", cnt_rdata, 2);
        rd_cnt();
        chk("R6 read reloads", cnt_rdata, 5);
        pulse_fast(5);
        chk("R5 zero", cnt_rdata, 0);
        chk("R5 flag", alarm_flag, 1);
        chk("R10 on rst_out", rst_out, 1);
        chk("R10 not on irq", irq, 0);
        measure(1'b0, n);
        chk("R9 pulse ticks", n, 1024);
        chk("R5 stopped at zero", cnt_rdata, 0);
        chk("R8 flag held", alarm_flag, 1);
        af_clr = 1; cyc(1); af_clr = 0;
        rd_cnt();
        chk("R6 restart after stop", cnt_rdata, 5);
        pulse_fast(1);
        chk("R6 running again", cnt_rdata, 4);
    endtask

    task automatic t_watchdog_irq();
        int n;
        wr_ctrl(8'h6F);
        rd_cnt();
        pulse_fast(5);
        chk("R10 on irq", irq, 1);
        chk("R10 not on rst_out", rst_out, 0);
        wr_ctrl(8'h66);
        chk("R10 latched steer", irq, 1);
        wr_ctrl(8'h6E);
        chk("R11 aie cleared still high", irq, 1);
        measure(1'b1, n);
        chk("R11 full pulse", n, 1024);
        chk("R11 irq low after", irq, 0);
    endtask

    initial begin
        cyc(3);
        rst = 0;
        cyc(1);
        t_reset();
        t_decode();
        t_storage();
        t_alarm();
        t_irq_gate();
        t_watchdog_rst();
        t_watchdog_irq();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule